// File: doc/BRIEF.md
# Character Cell Video Serializer

This block turns a stream of character codes and attribute bytes into the one-bit dot stream of a raster display. It runs from a free-running dot clock and marks the end of every character cell with `cell_take`. On that edge it captures the next code and its attribute bits from display memory. On the same edge it loads the glyph row for the code captured one cell earlier into a shift register. A glyph ROM outside the block is addressed from the captured code and the current glyph line. It must return the dot row combinationally, within the same clock.

The glyph line comes from a scan-line counter that `line_end` advances and `vret` clears. A double-height mode spreads one glyph over two character rows, and `bottom_half` picks the lower half. A double-width mode holds every dot for two clocks and takes a new character every second cell. After the shift register, the attributes are applied to each dot in a fixed order: underline, then reverse, then blink, then invisible, then blanking.

Every tenth scan line raises a row interrupt, so the host can supply the start address of the next character row. Every vertical retrace raises a retrace interrupt. Both interrupts are kept as separate pending flags until the host acknowledges them.

Top module: `cell_dot_serializer`

## Requirements
- R1: While `rst` is high, and in the first clock after it, `video_dot`, `video_hi`, `irq`, `irq_flags` and `scan_line` are all 0. The dot counter restarts from 0, so the first `cell_take` comes in the 8th clock after release.
- R2: Normal width mode works as follows.
  - `cell_take` is high for one clock every 8 clocks.
  - The code present at one `cell_take` edge is used for the next one. At that edge, `glyph_addr` = {code, glyph line} selects a row, and the returned 8-bit `glyph_row` is loaded.
  - The loaded row appears on `video_dot` MSB first. Dot k is shown during the (k+1)th clock after the load edge.
- R3: With `dbl_high` high, the glyph line in `glyph_addr[3:0]` is `scan_line`/2, plus 5 when `bottom_half` is high. With `dbl_high` low, it is `scan_line` itself.
- R4: With `dbl_wide` high, `cell_take` comes every 16 clocks, and every dot of the row is held on `video_dot` for two clocks.
- R5: Attribute bit 2 (reverse) inverts each dot.
- R6: Attribute bit 1 (underline) forces the dot on while `scan_line` is 9. This is applied before reverse.
- R7: Attribute bit 3 (blink) forces the dot off while `blink_phase` is high.
- R8: Attribute bit 4 (invisible) forces every dot of the cell off.
- R9: Attribute bit 0 (bold) makes `video_hi` equal to the final dot. Without bold, `video_hi` is 0.
- R10: In the clock after `hblank` or `vblank` is high, `video_dot` and `video_hi` are 0.
- R11: `line_end` advances `scan_line` from 0 to 9. The pulse that arrives at line 9 wraps it to 0 and sets `irq_flags[0]` (row interrupt).
- R12: `vret` sets `scan_line` to 0 and sets `irq_flags[1]` (retrace interrupt) on the next clock.
- R13: Each of the two flags stays set until `irq_ack` is high for one clock, which clears both.
  - An event in the same clock as `irq_ack` sets its flag anyway.
  - A second kind of event while one is pending sets its own flag as well.
  - `irq` is high exactly while any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| char_code | input | 8 | Character code from display memory |
| attr_in | input | 5 | Attribute bits: 0 bold, 1 underline, 2 reverse, 3 blink, 4 invisible |
| cell_take | output | 1 | High in the last clock of a cell; code, attribute and glyph row are taken at its edge |
| glyph_addr | output | 12 | Glyph ROM address {code, glyph line} |
| glyph_row | input | 8 | Dot row returned by the glyph ROM, leftmost dot in the MSB |
| dbl_high | input | 1 | Double-height line mode |
| bottom_half | input | 1 | Selects the lower glyph half in double-height mode |
| dbl_wide | input | 1 | Double-width mode |
| blink_phase | input | 1 | Blink phase, high while blinking cells are dark |
| hblank | input | 1 | Horizontal blanking |
| vblank | input | 1 | Vertical blanking |
| line_end | input | 1 | One-clock pulse at the end of each scan line |
| vret | input | 1 | One-clock pulse at the start of vertical retrace |
| irq_ack | input | 1 | Interrupt acknowledge pulse from the host |
| video_dot | output | 1 | Serial dot output |
| video_hi | output | 1 | High-intensity dot output |
| irq | output | 1 | Interrupt request |
| irq_flags | output | 2 | Pending flags: bit 0 row, bit 1 retrace |
| scan_line | output | 4 | Current scan line within the character row |

## Verification
A table of character, attribute and line vectors is run through the serializer, and the dot patterns are compared against a glyph function that the bench owns.

The vectors are chosen to tell apart the cases that a wrong design would confuse:
- Plain cells are checked against reverse cells.
- Underline is checked on line 9 and off it, alone and combined with reverse, which fixes the order of the two.
- Blink is checked with the phase high and with it low.
- Double-height cells are checked in both halves against the same scan line, which separates the halved-line address from the direct one.

Double width is recognised by every dot appearing twice and by the 16-clock cell spacing. Blanking is applied to a cell that would otherwise be lit. The interrupt sequences cover:
- a row interrupt alone;
- a retrace interrupt alone;
- both pending together;
- an event that arrives in the same clock as an acknowledge.

// File: rtl/cds_pkg.sv
`timescale 1ns/1ps
package cds_pkg;

  // Attribute byte layout; the first member is the MSB.
  typedef struct packed {
    logic invis;  // bit 4
    logic blink;  // bit 3
    logic rev;    // bit 2
    logic uline;  // bit 1
    logic bold;   // bit 0
  } cell_attr_t;

  localparam int ATTR_W = $bits(cell_attr_t);

  // Index of each interrupt kind in the pending flag vector.
  localparam int IRQ_ROW = 0;
  localparam int IRQ_RET = 1;

endpackage

// File: rtl/cds_cell_timer.sv
`timescale 1ns/1ps
// Free-running dot counter that decodes the load and shift strobes.
// DOTS must be a power of two.
module cds_cell_timer #(
  parameter int DOTS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic dbl_wide,
  output logic load,
  output logic shift_en
);
  localparam int DW = $clog2(DOTS);
  localparam int TW = DW + 1;

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) tcnt <= '0;
    else     tcnt <= tcnt + 1'b1;
  end

  always_comb begin
    if (dbl_wide) begin
      load     = (tcnt == TW'(2*DOTS-1));
      shift_en = tcnt[0];
    end else begin
      load     = (tcnt[DW-1:0] == DW'(DOTS-1));
      shift_en = 1'b1;
    end
  end
endmodule

// File: rtl/cds_scan_irq.sv
`timescale 1ns/1ps
// Scan-line counter within a character row, plus the interrupt flags.
module cds_scan_irq #(
  parameter int LINES = 10,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic          vret,
  input  logic          irq_ack,
  output logic [LW-1:0] scan_line,
  output logic [1:0]    irq_flags,
  output logic          irq
);
  import cds_pkg::*;

  logic [LW-1:0] scan_q;
  logic [1:0]    flags_q;
  logic          irq_q;
  logic          row_ev;
  logic [1:0]    flags_nxt;

  assign row_ev = line_end && (scan_q == LW'(LINES-1));

  always_comb begin
    // An acknowledge clears both flags, but an event in the same clock still sets its own.
    flags_nxt          = irq_ack ? 2'b00 : flags_q;
    flags_nxt[IRQ_ROW] = flags_nxt[IRQ_ROW] | row_ev;
    flags_nxt[IRQ_RET] = flags_nxt[IRQ_RET] | vret;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_q  <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (vret)        scan_q <= '0;
      else if (row_ev) scan_q <= '0;
      else if (line_end) scan_q <= scan_q + 1'b1;
      flags_q <= flags_nxt;
      irq_q   <= |flags_nxt;
    end
  end

  assign scan_line = scan_q;
  assign irq_flags = flags_q;
  assign irq       = irq_q;
endmodule

// File: rtl/cds_glyph_addr.sv
`timescale 1ns/1ps
// Builds the glyph ROM address from the code, the scan line and the double-height controls.
module cds_glyph_addr #(
  parameter int CODE_W = 8,
  parameter int LW     = 4,
  parameter int LINES  = 10
) (
  input  logic [CODE_W-1:0]    code,
  input  logic [LW-1:0]        scan_line,
  input  logic                 dbl_high,
  input  logic                 bottom_half,
  output logic [CODE_W+LW-1:0] addr
);
  localparam int HALF = LINES / 2;

  logic [LW-1:0] glyph_line;

  always_comb begin
    if (dbl_high)
      glyph_line = (scan_line >> 1) + (bottom_half ? LW'(HALF) : LW'(0));
    else
      glyph_line = scan_line;
    addr = {code, glyph_line};
  end
endmodule

// File: rtl/cds_dot_pipe.sv
`timescale 1ns/1ps
// Code and attribute latches, the attribute delay stage and the dot shift register.
module cds_dot_pipe #(
  parameter int CODE_W = 8,
  parameter int DOTS   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                shift_en,
  input  logic [CODE_W-1:0]   char_code,
  input  cds_pkg::cell_attr_t attr_in,
  input  logic [DOTS-1:0]     glyph_row,
  output logic [CODE_W-1:0]   code_q,
  output logic                dot,
  output cds_pkg::cell_attr_t attr_cur
);
  import cds_pkg::*;

  cell_attr_t      attr_q;
  cell_attr_t      attr_pipe;
  logic [DOTS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= '0;
      attr_q    <= '0;
      attr_pipe <= '0;
      shreg     <= '0;
    end else if (load) begin
      code_q    <= char_code;
      attr_q    <= attr_in;
      attr_pipe <= attr_q;      // stays with the row that is loaded now
      shreg     <= glyph_row;
    end else if (shift_en) begin
      shreg     <= {shreg[DOTS-2:0], 1'b0};
    end
  end

  assign dot      = shreg[DOTS-1];
  assign attr_cur = attr_pipe;
endmodule

// File: rtl/cds_attr_mixer.sv
`timescale 1ns/1ps
// Applies the attributes and blanking to each serial dot; outputs are registered.
module cds_attr_mixer #(
  parameter int LW      = 4,
  parameter int UL_LINE = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dot,
  input  cds_pkg::cell_attr_t attr,
  input  logic [LW-1:0]       scan_line,
  input  logic                blink_phase,
  input  logic                blank,
  output logic                video_dot,
  output logic                video_hi
);
  logic d_ul, d_rev, d_fin;

  always_comb begin
    d_ul  = dot | (attr.uline && (scan_line == LW'(UL_LINE)));
    d_rev = d_ul ^ attr.rev;
    d_fin = d_rev && !(attr.blink && blink_phase) && !attr.invis && !blank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      video_dot <= 1'b0;
      video_hi  <= 1'b0;
    end else begin
      video_dot <= d_fin;
      video_hi  <= d_fin & attr.bold;
    end
  end
endmodule

// File: rtl/cell_dot_serializer.sv
`timescale 1ns/1ps
module cell_dot_serializer #(
  parameter int CODE_W  = 8,
  parameter int DOTS    = 8,
  parameter int LINES   = 10,
  parameter int LW      = 4,
  parameter int UL_LINE = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CODE_W-1:0]    char_code,
  input  logic [4:0]           attr_in,
  output logic                 cell_take,
  output logic [CODE_W+LW-1:0] glyph_addr,
  input  logic [DOTS-1:0]      glyph_row,
  input  logic                 dbl_high,
  input  logic                 bottom_half,
  input  logic                 dbl_wide,
  input  logic                 blink_phase,
  input  logic                 hblank,
  input  logic                 vblank,
  input  logic                 line_end,
  input  logic                 vret,
  input  logic                 irq_ack,
  output logic                 video_dot,
  output logic                 video_hi,
  output logic                 irq,
  output logic [1:0]           irq_flags,
  output logic [LW-1:0]        scan_line
);
  import cds_pkg::*;

  logic              load, shift_en, dot;
  logic [CODE_W-1:0] code_q;
  cell_attr_t        attr_cur;

  cds_cell_timer #(.DOTS(DOTS)) u_timer (
    .clk(clk), .rst(rst), .dbl_wide(dbl_wide), .load(load), .shift_en(shift_en)
  );

  cds_scan_irq #(.LINES(LINES), .LW(LW)) u_scan (
    .clk(clk), .rst(rst), .line_end(line_end), .vret(vret), .irq_ack(irq_ack),
    .scan_line(scan_line), .irq_flags(irq_flags), .irq(irq)
  );

  cds_glyph_addr #(.CODE_W(CODE_W), .LW(LW), .LINES(LINES)) u_addr (
    .code(code_q), .scan_line(scan_line), .dbl_high(dbl_high),
    .bottom_half(bottom_half), .addr(glyph_addr)
  );

  cds_dot_pipe #(.CODE_W(CODE_W), .DOTS(DOTS)) u_pipe (
    .clk(clk), .rst(rst), .load(load), .shift_en(shift_en),
    .char_code(char_code), .attr_in(cell_attr_t'(attr_in)), .glyph_row(glyph_row),
    .code_q(code_q), .dot(dot), .attr_cur(attr_cur)
  );

  cds_attr_mixer #(.LW(LW), .UL_LINE(UL_LINE)) u_mix (
    .clk(clk), .rst(rst), .dot(dot), .attr(attr_cur), .scan_line(scan_line),
    .blink_phase(blink_phase), .blank(hblank | vblank),
    .video_dot(video_dot), .video_hi(video_hi)
  );

  assign cell_take = load;
endmodule

// File: rtl/cds_chk.sv
`timescale 1ns/1ps
module cds_chk #(
  parameter int LINES = 10,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cell_take,
  input logic          hblank,
  input logic          vblank,
  input logic          line_end,
  input logic          vret,
  input logic          irq_ack,
  input logic          video_dot,
  input logic          video_hi,
  input logic          irq,
  input logic [1:0]    irq_flags,
  input logic [LW-1:0] scan_line
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!video_dot && !video_hi && !irq && irq_flags == 2'b00 && scan_line == '0));

  // R2
  take_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cell_take |=> !cell_take);

  // R9
  bold_subset_chk: assert property (@(posedge clk) disable iff (rst)
    video_hi |-> video_dot);

  // R10
  blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (hblank || vblank) |=> (!video_dot && !video_hi));

  // R11
  scan_range_chk: assert property (@(posedge clk) disable iff (rst)
    scan_line <= LW'(LINES-1));

  // R11
  row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (line_end && !vret && scan_line == LW'(LINES-1)) |=> (scan_line == '0 && irq_flags[0]));

  // R12
  retrace_chk: assert property (@(posedge clk) disable iff (rst)
    vret |=> (scan_line == '0 && irq_flags[1]));

  // R13
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_flags != 2'b00 && !irq_ack) |=> ((irq_flags & $past(irq_flags)) == $past(irq_flags)));

  // R13
  irq_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_flags != 2'b00));
endmodule

bind cell_dot_serializer cds_chk #(.LINES(LINES), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .cell_take(cell_take), .hblank(hblank), .vblank(vblank),
  .line_end(line_end), .vret(vret), .irq_ack(irq_ack), .video_dot(video_dot),
  .video_hi(video_hi), .irq(irq), .irq_flags(irq_flags), .scan_line(scan_line)
);

// File: tb/test_cell_dot_serializer.sv
`timescale 1ns/1ps
module test_cell_dot_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  char_code = '0;
  logic [4:0]  attr_in = '0;
  logic        cell_take;
  logic [11:0] glyph_addr;
  logic [7:0]  glyph_row;
  logic        dbl_high = 0, bottom_half = 0, dbl_wide = 0, blink_phase = 0;
  logic        hblank = 0, vblank = 0, line_end = 0, vret = 0, irq_ack = 0;
  logic        video_dot, video_hi, irq;
  logic [1:0]  irq_flags;
  logic [3:0]  scan_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // Glyph ROM owned by the bench.
  function automatic logic [7:0] glyph(input logic [11:0] a);
    logic [7:0] m;
    m = a[11:4] * 8'd37;
    return m ^ {a[3:0], ~a[3:0]} ^ 8'h5A;
  endfunction

  assign glyph_row = glyph(glyph_addr);

  cell_dot_serializer i_cell_dot_serializer (
    .clk(clk), .rst(rst), .char_code(char_code), .attr_in(attr_in),
    .cell_take(cell_take), .glyph_addr(glyph_addr), .glyph_row(glyph_row),
    .dbl_high(dbl_high), .bottom_half(bottom_half), .dbl_wide(dbl_wide),
    .blink_phase(blink_phase), .hblank(hblank), .vblank(vblank),
    .line_end(line_end), .vret(vret), .irq_ack(irq_ack),
    .video_dot(video_dot), .video_hi(video_hi), .irq(irq),
    .irq_flags(irq_flags), .scan_line(scan_line)
  );

  // Vector: {code[19:12], attr[11:7], scan[6:3], dbl_high[2], bottom[1], blink_phase[0]}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {8'h41, 5'b00000, 4'd3, 1'b0, 1'b0, 1'b0},  // plain
    {8'h5A, 5'b00100, 4'd2, 1'b0, 1'b0, 1'b0},  // reverse
    {8'h33, 5'b00010, 4'd9, 1'b0, 1'b0, 1'b0},  // underline on line 9
    {8'h33, 5'b00010, 4'd4, 1'b0, 1'b0, 1'b0},  // underline off line 9
    {8'h7E, 5'b01000, 4'd1, 1'b0, 1'b0, 1'b1},  // blink, phase high
    {8'h7E, 5'b01000, 4'd1, 1'b0, 1'b0, 1'b0},  // blink, phase low
    {8'hC4, 5'b10000, 4'd5, 1'b0, 1'b0, 1'b0},  // invisible
    {8'h21, 5'b00001, 4'd6, 1'b0, 1'b0, 1'b0},  // bold
    {8'h48, 5'b00000, 4'd7, 1'b1, 1'b0, 1'b0},  // double high top
    {8'h48, 5'b00000, 4'd7, 1'b1, 1'b1, 1'b0},  // double high bottom
    {8'h19, 5'b00110, 4'd9, 1'b0, 1'b0, 1'b0},  // underline then reverse
    {8'hFF, 5'b00101, 4'd0, 1'b0, 1'b0, 1'b0}   // bold reverse
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2";   1: return "R5";   2: return "R6";   3: return "R6";
      4: return "R7";   5: return "R7";   6: return "R8";   7: return "R9";
      8: return "R3";   9: return "R3";   10: return "R6";  default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected dots after the attributes, from R3 and R5 to R9.
  function automatic logic [15:0] expect_row(input logic [7:0] code, input logic [4:0] at,
      input logic [3:0] sc, input bit dh, input bit bot, input bit bp);
    logic [3:0] gl;
    logic [7:0] raw, d, h;
    gl = dh ? ((sc >> 1) + (bot ? 4'd5 : 4'd0)) : sc;
    raw = glyph({code, gl});
    for (int i = 0; i < 8; i++) begin
      logic b;
      b = raw[i];
      if (at[1] && sc == 4'd9) b = 1'b1;
      if (at[2]) b = ~b;
      if (at[3] && bp) b = 1'b0;
      if (at[4]) b = 1'b0;
      d[i] = b;
      h[i] = b & at[0];
    end
    return {h, d};
  endfunction

  task automatic pulse_line;
    @(negedge clk) line_end = 1;
    @(negedge clk) line_end = 0;
  endtask
  task automatic pulse_vret;
    @(negedge clk) vret = 1;
    @(negedge clk) vret = 0;
  endtask
  task automatic pulse_ack;
    @(negedge clk) irq_ack = 1;
    @(negedge clk) irq_ack = 0;
  endtask
  task automatic set_scan(input int n);
    pulse_vret();
    for (int i = 0; i < n; i++) pulse_line();
    pulse_ack();
  endtask
  task automatic wait_load;
    do @(negedge clk); while (!cell_take);
    @(posedge clk);
  endtask
  // Samples n dots, the first one landing in bit n-1.
  task automatic capture(input int n, output logic [15:0] d, output logic [15:0] h);
    d = '0; h = '0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      d = {d[14:0], video_dot};
      h = {h[14:0], video_hi};
    end
  endtask
  task automatic spacing(output int cnt);
    do @(negedge clk); while (!cell_take);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!cell_take);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, h, e, w;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(!video_dot && !video_hi && !irq && irq_flags == 0 && scan_line == 0, "R1 reset state",
          {video_dot, video_hi, irq, irq_flags, scan_line}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      set_scan(int'(v[6:3]));
      char_code = v[19:12]; attr_in = v[11:7];
      dbl_high = v[2]; bottom_half = v[1]; blink_phase = v[0];
      e = expect_row(v[19:12], v[11:7], v[6:3], v[2], v[1], v[0]);
      wait_load(); wait_load();
      capture(8, d, h);
      check(d[7:0] == e[7:0], $sformatf("%s vector %0d dots", vec_tag(i), i), d[7:0], e[7:0]);
      check(h[7:0] == e[15:8], $sformatf("R9 vector %0d bright", i), h[7:0], e[15:8]);
    end
    dbl_high = 0; bottom_half = 0; blink_phase = 0;

    // R2: cell spacing in normal width
    spacing(cnt);
    check(cnt == 8, "R2 cell spacing", cnt, 8);

    // R4: double width doubles every dot and the cell spacing
    @(negedge clk);
    set_scan(3);
    char_code = 8'h41; attr_in = 5'b00000; dbl_wide = 1;
    e = expect_row(8'h41, 5'b0, 4'd3, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin w[2*i] = e[i]; w[2*i+1] = e[i]; end
    wait_load(); wait_load();
    capture(16, d, h);
    check(d == w, "R4 double width dots", d, w);
    spacing(cnt);
    check(cnt == 16, "R4 double width spacing", cnt, 16);
    @(negedge clk) dbl_wide = 0;

    // R10: blanking darkens a lit cell
    set_scan(2);
    char_code = 8'h5A; attr_in = 5'b00101; hblank = 1;
    wait_load(); wait_load();
    capture(8, d, h);
    check(d[7:0] == 0 && h[7:0] == 0, "R10 hblank dark", {d[7:0], h[7:0]}, 0);
    @(negedge clk) hblank = 0; vblank = 1;
    wait_load(); wait_load();
    capture(8, d, h);
    check(d[7:0] == 0 && h[7:0] == 0, "R10 vblank dark", {d[7:0], h[7:0]}, 0);
    @(negedge clk) vblank = 0;

    // R12: retrace interrupt
    pulse_vret();
    check(irq && irq_flags == 2'b10 && scan_line == 0, "R12 retrace flag", {irq, irq_flags}, 3'b110);
    pulse_ack();
    check(!irq && irq_flags == 2'b00, "R13 ack clears", {irq, irq_flags}, 0);

    // R11: nine lines give no interrupt, the tenth does
    for (int i = 0; i < 9; i++) pulse_line();
    check(irq_flags == 2'b00 && scan_line == 4'd9, "R11 no early row irq", {irq_flags, scan_line}, 6'd9);
    pulse_line();
    check(irq && irq_flags == 2'b01 && scan_line == 0, "R11 row irq", {irq, irq_flags, scan_line}, 7'h50);

    // R13: a retrace during a pending row interrupt keeps both
    pulse_vret();
    check(irq_flags == 2'b11, "R13 both pending", irq_flags, 2'b11);
    pulse_ack();
    check(irq_flags == 2'b00 && !irq, "R13 ack clears both", {irq, irq_flags}, 0);

    // R13: an event in the same clock as an acknowledge wins
    for (int i = 0; i < 9; i++) pulse_line();
    @(negedge clk) begin line_end = 1; irq_ack = 1; end
    @(negedge clk) begin line_end = 0; irq_ack = 0; end
    check(irq && irq_flags == 2'b01, "R13 event beats ack", {irq, irq_flags}, 3'b101);

    // R1: reset mid-run clears pending state
    pulse_vret();
    @(negedge clk) rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!irq && irq_flags == 0 && scan_line == 0 && !video_dot, "R1 reset mid-run",
          {irq, irq_flags, scan_line}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule